// File: doc/BRIEF.md
# Rotating Event Buffer Ring with Occupancy Lines

This block is the bookkeeping for a ring of event buffers. Every incoming event is handed the next slot of the ring in strict rotation, even when only two or three slots are in use at once. Three pointers are kept in step: the slot that holds the event now being handled, the slot that the following event will use, and a slot one further ahead that is being wiped in advance. Because of this, a switch to a new slot always lands on a clean buffer. Each time the ring steps forward, a one-cycle request tells the clearing logic to start on the newly designated slot.

The block also keeps a count of occupied buffers. It drives that count out as a cumulative thermometer code, which suits a logic analyser or scaler gates directly. It also drives a four-line reduced-resolution code. The width of the thermometer is a parameter, so the same block can serve an input-side ring with 16 lines or an output-side ring limited to 8 lines.

Top module: `ebr_ring`

## Requirements
- R1: In reset (synchronous, active high) the current index is 0, the next index is 1 and the clear index is 2. The clear request, full flag, overflow flag and all occupancy lines are 0.
- R2: An accepted arrival moves the current index to the old next index and advances the next index by one modulo 16, so successive arrivals visit slots 0 to 15 in increasing order and wrap.
- R3: The clear index always equals the next index plus one modulo 16, so it never equals the next index or the current index.
- R4: The clear request is high for exactly the one cycle after each accepted arrival, and is low in every other cycle.
- R5: An arrival while 16 buffers are occupied is rejected. The pointers do not move and the overflow flag rises. The flag then stays high until reset, and a release in the same cycle still takes effect.
- R6: The occupied count rises by one on an accepted arrival and falls by one on a release. An accepted arrival together with a release leaves it unchanged, and a release at count 0 is ignored. The full flag is high exactly when the count is 16.
- R7: Thermometer line k (bit k of the occupancy output) is high exactly when k+1 or more buffers are occupied. With an 8-line configuration, bit 7 means 8 or more.
- R8: Reduced occupancy bit 0 is high for 2 or more occupied buffers, bit 1 for 4 or more, bit 2 for 14 or more and bit 3 for 16.
- R9: All outputs are registered and reflect the strobes sampled at a clock edge immediately after that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_arrive | input | 1 | One-cycle strobe: an event claims the next slot |
| buf_release | input | 1 | One-cycle strobe: one occupied buffer is freed |
| cur_idx | output | 4 | Slot holding the current event |
| nxt_idx | output | 4 | Slot designated for the next event |
| clr_idx | output | 4 | Slot being cleared ahead of use |
| clr_req | output | 1 | One-cycle pulse to start clearing clr_idx |
| full | output | 1 | All 16 buffers occupied |
| overflow | output | 1 | Sticky: an arrival was rejected while full |
| occ_therm | output | THERM_LINES | Cumulative decoded occupancy |
| occ_coarse | output | 4 | Reduced-resolution occupancy thresholds |

## Verification
On every cycle, the assertions check the following:
- the fixed spacing of the three pointers,
- that the clear slot never coincides with the slot about to be filled,
- the count bound and its agreement with the full flag,
- the stickiness of overflow,
- the contiguous shape of the thermometer and the nesting of the reduced code,
- that a rejected arrival leaves the pointers still.

Only the bench's scenarios can show that the count and codes carry the right values. These include filling to sixteen and draining to zero line by line, simultaneous strobes at full and at empty, many wraps of the ring, and an 8-line instance driven alongside the default one.

// File: rtl/ebr_pkg.sv
`timescale 1ns/1ps
package ebr_pkg;

  // Counter update selected each cycle
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2
  } cnt_op_e;

  // Number of lines in the reduced-resolution code
  localparam int unsigned COARSE_LINES = 4;

  // Occupancy threshold for reduced line j in a ring of n slots
  function automatic int unsigned coarse_threshold(input int unsigned j,
                                                   input int unsigned n);
    case (j)
      0:       return 2;
      1:       return 4;
      2:       return n - 2;
      default: return n;
    endcase
  endfunction

endpackage

// File: rtl/ebr_ring_ptr.sv
`timescale 1ns/1ps
module ebr_ring_ptr #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] cur_o,
  output logic [IDX_W-1:0] nxt_o,
  output logic [IDX_W-1:0] clr_o,
  output logic             clr_req_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  function automatic logic [IDX_W-1:0] ring_inc(input logic [IDX_W-1:0] v);
    return (v == LAST_IDX) ? '0 : v + 1'b1;
  endfunction

  logic [IDX_W-1:0] cur_q, nxt_q, clr_q;
  logic             req_q;

  // The ring steps as a whole: each pointer takes its neighbour's slot
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      nxt_q <= IDX_W'(1);
      clr_q <= IDX_W'(2);
      req_q <= 1'b0;
    end else begin
      req_q <= advance;
      if (advance) begin
        cur_q <= nxt_q;
        nxt_q <= clr_q;
        clr_q <= ring_inc(clr_q);
      end
    end
  end

  assign cur_o     = cur_q;
  assign nxt_o     = nxt_q;
  assign clr_o     = clr_q;
  assign clr_req_o = req_q;

  AST_NEXT_FOLLOWS_CUR: assert property (@(posedge clk) disable iff (rst)
    nxt_q == ring_inc(cur_q));                                          // R2

  AST_CLEAR_AHEAD: assert property (@(posedge clk) disable iff (rst)
    clr_q == ring_inc(nxt_q));                                          // R3

  AST_ADVANCE_HANDOVER: assert property (@(posedge clk) disable iff (rst)
    advance |=> (cur_q == $past(nxt_q)) && req_q);                      // R4

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !advance |=> !req_q && $stable(cur_q));                             // R4

endmodule

// File: rtl/ebr_occ_counter.sv
`timescale 1ns/1ps
module ebr_occ_counter
  import ebr_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned CNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arrive,
  input  logic             release_i,
  output logic             accept_o,
  output logic [CNT_W-1:0] count_nxt_o,
  output logic             full_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_SLOTS);

  logic [CNT_W-1:0] count_q, count_d;
  logic             full_q, ovf_q;
  logic             accept, drop;
  cnt_op_e          op;

  always_comb begin
    accept = arrive && !full_q;
    drop   = release_i && (count_q != '0);
    unique case ({accept, drop})
      2'b10:   op = CNT_INC;
      2'b01:   op = CNT_DEC;
      default: op = CNT_HOLD;
    endcase
    unique case (op)
      CNT_INC: count_d = count_q + 1'b1;
      CNT_DEC: count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      full_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      full_q  <= (count_d == CNT_MAX);
      ovf_q   <= ovf_q | (arrive & full_q);
    end
  end

  assign accept_o    = accept;
  assign count_nxt_o = count_d;
  assign full_o      = full_q;
  assign ovf_o       = ovf_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_MAX);                                                // R6

  AST_FULL_AGREES: assert property (@(posedge clk) disable iff (rst)
    full_q == (count_q == CNT_MAX));                                    // R6

  AST_OVF_ON_REJECT: assert property (@(posedge clk) disable iff (rst)
    (arrive && full_q) |=> ovf_q);                                      // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);                                                   // R5

endmodule

// File: rtl/ebr_occ_decode.sv
`timescale 1ns/1ps
module ebr_occ_decode
  import ebr_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 16,
  parameter int unsigned CNT_W       = $clog2(NUM_SLOTS + 1),
  parameter int unsigned THERM_LINES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CNT_W-1:0]        count_i,
  output logic [THERM_LINES-1:0]  therm_o,
  output logic [COARSE_LINES-1:0] coarse_o
);

  logic [THERM_LINES-1:0]  therm_d, therm_q;
  logic [COARSE_LINES-1:0] coarse_d, coarse_q;

  // Line k of the thermometer: k+1 or more occupied
  for (genvar k = 0; k < THERM_LINES; k++) begin : g_therm
    assign therm_d[k] = (count_i >= CNT_W'(k + 1));
  end

  // Reduced code with nonuniform thresholds
  for (genvar j = 0; j < COARSE_LINES; j++) begin : g_coarse
    localparam int unsigned TH = coarse_threshold(j, NUM_SLOTS);
    assign coarse_d[j] = (count_i >= CNT_W'(TH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      therm_q  <= '0;
      coarse_q <= '0;
    end else begin
      therm_q  <= therm_d;
      coarse_q <= coarse_d;
    end
  end

  assign therm_o  = therm_q;
  assign coarse_o = coarse_q;

  AST_THERM_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
    ((({1'b0, therm_q} + 1'b1) & {1'b0, therm_q}) == '0));              // R7

  AST_COARSE_NESTED: assert property (@(posedge clk) disable iff (rst)
    (!coarse_q[3] || coarse_q[2]) && (!coarse_q[2] || coarse_q[1]) &&
    (!coarse_q[1] || coarse_q[0]));                                     // R8

endmodule

// File: rtl/ebr_ring.sv
`timescale 1ns/1ps
module ebr_ring
  import ebr_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 16,
  parameter int unsigned THERM_LINES = 16,
  localparam int unsigned IDX_W      = $clog2(NUM_SLOTS),
  localparam int unsigned CNT_W      = $clog2(NUM_SLOTS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    evt_arrive,
  input  logic                    buf_release,
  output logic [IDX_W-1:0]        cur_idx,
  output logic [IDX_W-1:0]        nxt_idx,
  output logic [IDX_W-1:0]        clr_idx,
  output logic                    clr_req,
  output logic                    full,
  output logic                    overflow,
  output logic [THERM_LINES-1:0]  occ_therm,
  output logic [COARSE_LINES-1:0] occ_coarse
);

  logic             accept;
  logic [CNT_W-1:0] count_nxt;

  ebr_occ_counter #(
    .NUM_SLOTS (NUM_SLOTS),
    .CNT_W     (CNT_W)
  ) u_count (
    .clk         (clk),
    .rst         (rst),
    .arrive      (evt_arrive),
    .release_i   (buf_release),
    .accept_o    (accept),
    .count_nxt_o (count_nxt),
    .full_o      (full),
    .ovf_o       (overflow)
  );

  ebr_ring_ptr #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
  ) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .advance   (accept),
    .cur_o     (cur_idx),
    .nxt_o     (nxt_idx),
    .clr_o     (clr_idx),
    .clr_req_o (clr_req)
  );

  ebr_occ_decode #(
    .NUM_SLOTS   (NUM_SLOTS),
    .CNT_W       (CNT_W),
    .THERM_LINES (THERM_LINES)
  ) u_decode (
    .clk      (clk),
    .rst      (rst),
    .count_i  (count_nxt),
    .therm_o  (occ_therm),
    .coarse_o (occ_coarse)
  );

  AST_NO_ADVANCE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (evt_arrive && full) |=> $stable(cur_idx) && !clr_req);             // R5

  AST_CLEAR_SLOT_GUARDED: assert property (@(posedge clk) disable iff (rst)
    (clr_idx != nxt_idx) && (clr_idx != cur_idx));                      // R3

  AST_FULL_TOP_LINE: assert property (@(posedge clk) disable iff (rst)
    full == occ_coarse[3]);                                             // R8

endmodule

// File: tb/ebr_ring_test.sv
`timescale 1ns/1ps
module ebr_ring_test;

  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt = 1'b0;
  logic rel = 1'b0;

  logic [3:0]  cur_idx, nxt_idx, clr_idx;
  logic        clr_req, full, overflow;
  logic [15:0] occ_therm;
  logic [3:0]  occ_coarse;

  logic [3:0]  cur8, nxt8, clr8;
  logic        req8, full8, ovf8;
  logic [7:0]  therm8;
  logic [3:0]  coarse8;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int exp_cnt = 0;
  int exp_cur = 0;
  bit exp_ovf = 0;
  bit exp_req = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  ebr_ring #(.NUM_SLOTS(16), .THERM_LINES(16)) uut (
    .clk(clk), .rst(rst), .evt_arrive(evt), .buf_release(rel),
    .cur_idx(cur_idx), .nxt_idx(nxt_idx), .clr_idx(clr_idx),
    .clr_req(clr_req), .full(full), .overflow(overflow),
    .occ_therm(occ_therm), .occ_coarse(occ_coarse)
  );

  ebr_ring #(.NUM_SLOTS(16), .THERM_LINES(8)) uut8 (
    .clk(clk), .rst(rst), .evt_arrive(evt), .buf_release(rel),
    .cur_idx(cur8), .nxt_idx(nxt8), .clr_idx(clr8),
    .clr_req(req8), .full(full8), .overflow(ovf8),
    .occ_therm(therm8), .occ_coarse(coarse8)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [15:0] th16;
    logic [7:0]  th8;
    logic [3:0]  co;
    for (int k = 0; k < 16; k++) th16[k] = (exp_cnt >= k + 1);
    for (int k = 0; k < 8; k++)  th8[k]  = (exp_cnt >= k + 1);
    co[0] = (exp_cnt >= 2);
    co[1] = (exp_cnt >= 4);
    co[2] = (exp_cnt >= 14);
    co[3] = (exp_cnt >= 16);
    chk("R2 current index", 32'(cur_idx), 32'(exp_cur));
    chk("R2 next index", 32'(nxt_idx), 32'((exp_cur + 1) % N));
    chk("R3 clear index", 32'(clr_idx), 32'((exp_cur + 2) % N));
    chk("R4 clear request", 32'(clr_req), 32'(exp_req));
    chk("R5 overflow", 32'(overflow), 32'(exp_ovf));
    chk("R6 full", 32'(full), 32'(exp_cnt == N));
    chk("R7 thermometer 16", 32'(occ_therm), 32'(th16));
    chk("R7 thermometer 8", 32'(therm8), 32'(th8));
    chk("R8 reduced code", 32'(occ_coarse), 32'(co));
    chk("R9 8-line ring pointer", 32'(cur8), 32'(exp_cur));
  endtask

  // R9: strobes driven at the falling edge, results sampled 1 ns after the rise
  task automatic step(input bit a, input bit r);
    bit acc;
    @(negedge clk);
    evt = a;
    rel = r;
    @(posedge clk);
    acc = a && (exp_cnt < N);
    if (a && exp_cnt == N) exp_ovf = 1;
    if (acc) exp_cur = (exp_cur + 1) % N;
    exp_cnt = exp_cnt + (acc ? 1 : 0) - ((r && exp_cnt > 0) ? 1 : 0);
    exp_req = acc;
    #1;
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    evt = 1'b0;
    rel = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_cnt = 0; exp_cur = 0; exp_ovf = 0; exp_req = 0;
    #1;
    // R1: reset values
    chk("R1 reset current", 32'(cur_idx), 32'd0);
    chk("R1 reset next", 32'(nxt_idx), 32'd1);
    chk("R1 reset clear", 32'(clr_idx), 32'd2);
    chk("R1 reset flags", 32'({clr_req, full, overflow}), 32'd0);
    chk("R1 reset occupancy", 32'({occ_therm, occ_coarse}), 32'd0);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    do_reset();
    // R6 R7 R8: fill line by line to 16
    for (int i = 0; i < N; i++) step(1, 0);
    // R5: rejected arrivals at full, then arrival with release at full
    for (int i = 0; i < 3; i++) step(1, 0);
    step(1, 1);
    step(1, 0);
    // R6: drain to zero and beyond
    for (int i = 0; i < N + 3; i++) step(0, 1);
    // R6: simultaneous strobes at empty and mid-range
    step(1, 1);
    for (int i = 0; i < 5; i++) step(1, 0);
    for (int i = 0; i < 4; i++) step(1, 1);
    step(0, 0);
    // R2 R3: many wraps with occupancy held low
    do_reset();
    for (int i = 0; i < 3 * N + 5; i++) begin
      step(1, 0);
      step(0, 1);
    end
    // mixed pattern over all counts
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | (lfsr[5] & lfsr[9]), lfsr[3]);
    end
    do_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule